// File: doc/BRIEF.md
# Gray-Coded Counter Domain Crossing

This block carries the value of a free-running up-counter from one clock domain into a second, unrelated clock domain. The receiving side only ever sees a value that the counter actually held. In the source domain a binary counter advances once on every clock edge where the increment enable is high, and wraps from all ones back to zero. Alongside it, a register holds the reflected-binary (Gray) form of the count. That Gray register is the only signal that crosses domains.

In the destination domain, each Gray bit passes through its own chain of flip-flops. Nothing sits between the source register and the first flop of the chain. The resolved Gray word is then decoded back to binary and registered as the output. The block is meant for progress pointers that one domain publishes and another reads, such as the write and read positions of a dual-clock queue.

Because successive counts differ in one Gray bit only, a sample taken while the source is changing resolves to either the old count or the new one. A plain binary crossing lacks this property: a 4-bit step from 7 to 8 flips every bit, and could be seen as 0, 15 or any other mix.

Top module: `gray_count_xfer`

## Requirements
- R1: While the destination reset is low, `dstCount` is 0. While the source reset is low, the source count is 0, and once the destination has settled it reads 0.
- R2: On each source clock edge with `incEn` high, the count rises by one. With `incEn` low, it keeps its value.
- R3: An increment from the all-ones value gives zero. On the destination side, this shows as a step from 2^CNT_W-1 to 0.
- R4: The code that crosses domains is the registered value count XOR (count >> 1). Two successive codes differ in at most one bit, and in exactly one bit when the count advanced.
- R5: Each Gray bit has its own synchronizer chain of SYNC_STAGES flops (SYNC_STAGES of at least 2), and the first flop is fed straight from the source register. Bit i of the decoded binary is the XOR of Gray bits i up to CNT_W-1.
- R6: When the source clock is slower than the destination clock, two successive values of `dstCount` differ by 0 or by +1 modulo 2^CNT_W.
- R7: If the clock edges do not coincide and the source has been idle, a single increment first appears on `dstCount` exactly SYNC_STAGES+1 destination edges after the source edge that registered it. After SYNC_STAGES edges the old value is still shown.
- R8: After the source has been idle for SYNC_STAGES+2 destination cycles, `dstCount` equals the source count. This also holds after the destination reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| srcClk | input | 1 | Source domain clock |
| srcRstN | input | 1 | Source domain asynchronous reset, active low |
| incEn | input | 1 | Advance the counter by one on this source edge |
| dstClk | input | 1 | Destination domain clock |
| dstRstN | input | 1 | Destination domain asynchronous reset, active low |
| dstCount | output | CNT_W | Count decoded in the destination domain |

## Verification
On every source cycle, the assertions check the source-side rules: the count steps by one or holds, it wraps from all ones to zero, the transmitted code changes in at most one bit, and both resets clear their side. Properties cannot express the cross-domain behaviours, because they depend on how the two clocks are related. The bench scenarios cover these instead: the exact latency of a single step, outputs that only hold or step by one while the source is slow, the wrap seen at the far side, and convergence to the true count after random bursts with a fast source and after each reset.

// File: rtl/gcx_pkg.sv
package gcx_pkg;
  // Strobes issued by the source control to the source datapath.
  typedef struct packed {
    logic advance;  // count up by one
    logic wrap;     // return to zero from all ones
  } cntStrobe_t;
endpackage

// File: rtl/gcx_src_ctrl.sv
module gcx_src_ctrl
  import gcx_pkg::*;
(
  input  logic       incEn,
  input  logic       atMax,
  output cntStrobe_t strb
);
  always_comb begin
    strb.advance = incEn && !atMax;
    strb.wrap    = incEn && atMax;
  end
endmodule

// File: rtl/gcx_src_path.sv
module gcx_src_path
  import gcx_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             srcClk,
  input  logic             srcRstN,
  input  cntStrobe_t       strb,
  output logic             atMax,
  output logic [CNT_W-1:0] binCnt,
  output logic [CNT_W-1:0] grayTx
);
  logic [CNT_W-1:0] binNext;

  assign binNext = binCnt + 1'b1;
  assign atMax   = &binCnt;

  // The Gray code is registered so that only flop outputs reach the crossing.
  always_ff @(posedge srcClk or negedge srcRstN) begin
    if (!srcRstN) begin
      binCnt <= '0;
      grayTx <= '0;
    end else if (strb.wrap) begin
      binCnt <= '0;
      grayTx <= '0;
    end else if (strb.advance) begin
      binCnt <= binNext;
      grayTx <= binNext ^ (binNext >> 1);
    end
  end
endmodule

// File: rtl/gcx_dst_sync.sv
module gcx_dst_sync #(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             dstClk,
  input  logic             dstRstN,
  input  logic [CNT_W-1:0] grayIn,
  output logic [CNT_W-1:0] dstCount
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [CNT_W-1:0] grayRes;
  logic [CNT_W-1:0] binDec;

  // One independent flop chain per Gray bit; stage 0 takes the foreign bit directly.
  for (genvar b = 0; b < CNT_W; b++) begin : g_bit
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge dstClk or negedge dstRstN) begin
      if (!dstRstN) chain <= '0;
      else          chain <= {chain[SYNC_STAGES-2:0], grayIn[b]};
    end
    assign grayRes[b] = chain[LAST];
  end

  // Binary bit i is the parity of Gray bits i and above.
  for (genvar i = 0; i < CNT_W; i++) begin : g_dec
    assign binDec[i] = ^grayRes[CNT_W-1:i];
  end

  always_ff @(posedge dstClk or negedge dstRstN) begin
    if (!dstRstN) dstCount <= '0;
    else          dstCount <= binDec;
  end
endmodule

// File: rtl/gray_count_xfer.sv
module gray_count_xfer
  import gcx_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             srcClk,
  input  logic             srcRstN,
  input  logic             incEn,
  input  logic             dstClk,
  input  logic             dstRstN,
  output logic [CNT_W-1:0] dstCount
);
  cntStrobe_t       strb;
  logic             atMax;
  logic [CNT_W-1:0] binCnt;
  logic [CNT_W-1:0] grayTx;

  gcx_src_ctrl u_ctrl (
    .incEn (incEn),
    .atMax (atMax),
    .strb  (strb)
  );

  gcx_src_path #(.CNT_W(CNT_W)) u_path (
    .srcClk  (srcClk),
    .srcRstN (srcRstN),
    .strb    (strb),
    .atMax   (atMax),
    .binCnt  (binCnt),
    .grayTx  (grayTx)
  );

  gcx_dst_sync #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .dstClk   (dstClk),
    .dstRstN  (dstRstN),
    .grayIn   (grayTx),
    .dstCount (dstCount)
  );
endmodule

// File: rtl/gray_count_xfer_chk.sv
module gray_count_xfer_chk #(
  parameter int CNT_W = 4
) (
  input logic             srcClk,
  input logic             srcRstN,
  input logic             incEn,
  input logic [CNT_W-1:0] binCnt,
  input logic [CNT_W-1:0] grayTx,
  input logic             dstClk,
  input logic             dstRstN,
  input logic [CNT_W-1:0] dstCount
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  p_src_reset_r1: assert property (@(posedge srcClk)
    !srcRstN |-> (binCnt == '0 && grayTx == '0));

  p_dst_reset_r1: assert property (@(posedge dstClk)
    !dstRstN |-> dstCount == '0);

  p_step_r2: assert property (@(posedge srcClk) disable iff (!srcRstN)
    (incEn && binCnt != ALL_ONES) |=> binCnt == CNT_W'($past(binCnt) + 1'b1));

  p_hold_r2: assert property (@(posedge srcClk) disable iff (!srcRstN)
    !incEn |=> $stable(binCnt));

  p_wrap_r3: assert property (@(posedge srcClk) disable iff (!srcRstN)
    (incEn && binCnt == ALL_ONES) |=> binCnt == '0);

  p_one_bit_r4: assert property (@(posedge srcClk) disable iff (!srcRstN)
    incEn |=> $countones(grayTx ^ $past(grayTx)) == 1);

  p_no_flip_r4: assert property (@(posedge srcClk) disable iff (!srcRstN)
    !incEn |=> $stable(grayTx));
endmodule

bind gray_count_xfer gray_count_xfer_chk #(.CNT_W(CNT_W)) u_chk (
  .srcClk   (srcClk),
  .srcRstN  (srcRstN),
  .incEn    (incEn),
  .binCnt   (binCnt),
  .grayTx   (grayTx),
  .dstClk   (dstClk),
  .dstRstN  (dstRstN),
  .dstCount (dstCount)
);

// File: tb/gray_count_xfer_tb.sv
`timescale 1ns/1ps
module gray_count_xfer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 4;
  localparam int STAGES     = 2;
  localparam int MASK       = (1 << CNT_W) - 1;

  logic             srcClk = 1'b0;
  logic             dstClk = 1'b0;
  logic             srcRstN = 1'b0;
  logic             dstRstN = 1'b0;
  logic             incEn = 1'b0;
  logic [CNT_W-1:0] dstCount;

  int  srcHalf = 13;
  int  model = 0;
  int  nChecks = 0;
  int  nFail = 0;
  bit  stepWatch = 1'b0;
  bit  sawWrap = 1'b0;
  int  prevOut = 0;
  bit  done = 1'b0;

  gray_count_xfer #(.CNT_W(CNT_W), .SYNC_STAGES(STAGES)) u_dut (
    .srcClk   (srcClk),
    .srcRstN  (srcRstN),
    .incEn    (incEn),
    .dstClk   (dstClk),
    .dstRstN  (dstRstN),
    .dstCount (dstCount)
  );

  // Destination edges land on whole nanoseconds, source edges on x.3 ns: never together.
  initial forever #(CLK_PERIOD / 2) dstClk = ~dstClk;
  initial begin
    #0.3;
    forever #(srcHalf) srcClk = ~srcClk;
  end

  function automatic int nextVal(int v);
    return (v + 1) & MASK;
  endfunction

  function automatic int stepOf(int newV, int oldV);
    return (newV - oldV) & MASK;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference count, built from the port stimulus.
  always @(posedge srcClk or negedge srcRstN) begin
    if (!srcRstN)   model <= 0;
    else if (incEn) model <= nextVal(model);
  end

  // Step monitor for the slow-source phase (R6, R3).
  always @(negedge dstClk) begin
    if (stepWatch) begin
      chk(stepOf(int'(dstCount), prevOut) <= 1, "R6 step 0 or +1", stepOf(int'(dstCount), prevOut), 1);
      if (prevOut == MASK && int'(dstCount) == 0) sawWrap = 1'b1;
    end
    prevOut = int'(dstCount);
  end

  task automatic idleDst(int n);
    incEn = 1'b0;
    repeat (n) @(posedge dstClk);
    #1;
  endtask

  task automatic settleCheck(string req);
    @(negedge srcClk) incEn = 1'b0;
    idleDst(STAGES + 4);
    chk(int'(dstCount) == model, req, int'(dstCount), model);
  endtask

  task automatic randomRun(int cycles);
    for (int k = 0; k < cycles; k++) begin
      @(negedge srcClk);
      incEn = (($urandom % 4) != 0);
    end
    @(negedge srcClk) incEn = 1'b0;
  endtask

  task automatic singleStep();
    int expOld;
    idleDst(STAGES + 6);
    expOld = model;
    @(negedge srcClk) incEn = 1'b1;
    @(posedge srcClk);
    #0.1 incEn = 1'b0;
    repeat (STAGES) @(posedge dstClk);
    #1 chk(int'(dstCount) == expOld, "R7 old value after SYNC_STAGES edges", int'(dstCount), expOld);
    @(posedge dstClk);
    #1 chk(int'(dstCount) == nextVal(expOld), "R7 new value after SYNC_STAGES+1 edges", int'(dstCount), nextVal(expOld));
  endtask

  initial begin
    void'($urandom(32'd4660));
    repeat (3) @(posedge dstClk);
    #1 chk(dstCount == '0, "R1 output zero in reset", int'(dstCount), 0);
    srcRstN = 1'b1;
    dstRstN = 1'b1;
    idleDst(4);
    chk(dstCount == '0, "R1 zero after release", int'(dstCount), 0);

    // Exact latency of isolated increments (R7, R5).
    for (int k = 0; k < 3; k++) singleStep();

    // Idle input holds the count (R2).
    idleDst(20);
    chk(int'(dstCount) == model && model == 3, "R2 hold with incEn low", int'(dstCount), 3);

    // Slow source, random enables, every output step checked (R6, R3).
    prevOut = int'(dstCount);
    stepWatch = 1'b1;
    randomRun(300);
    settleCheck("R8 settled after slow burst");
    stepWatch = 1'b0;
    chk(sawWrap, "R3 wrap 15 to 0 seen at destination", int'(sawWrap), 1);

    // Fast source, random enables (R2, R8).
    srcHalf = 3;
    randomRun(500);
    settleCheck("R2 count matches after fast burst");

    // Directed wrap: exactly one full lap plus five lands on start plus five (R3).
    begin
      int startV;
      startV = model;
      for (int k = 0; k < (MASK + 1) + 5; k++) begin
        @(negedge srcClk) incEn = 1'b1;
      end
      settleCheck("R3 lap wraps to expected value");
      chk(int'(dstCount) == ((startV + 5) & MASK), "R3 lap arithmetic", int'(dstCount), (startV + 5) & MASK);
    end

    // Destination reset while the source keeps counting (R1, R8).
    fork
      randomRun(40);
      begin
        repeat (5) @(posedge dstClk);
        #1 dstRstN = 1'b0;
        repeat (3) @(posedge dstClk);
        #1 chk(dstCount == '0, "R1 destination reset clears output", int'(dstCount), 0);
        dstRstN = 1'b1;
      end
    join
    settleCheck("R8 resynchronized after destination reset");

    // Source reset returns the far side to zero (R1).
    @(negedge srcClk) srcRstN = 1'b0;
    repeat (2) @(negedge srcClk);
    srcRstN = 1'b1;
    settleCheck("R1 source reset reaches destination");
    chk(dstCount == '0, "R1 zero after source reset", int'(dstCount), 0);

    // Slow source again after reset, single steps (R7).
    srcHalf = 13;
    singleStep();
    singleStep();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge dstClk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end
endmodule